// File: doc/BRIEF.md
# External memory bus strobe controller

This block sets the timing of an 8-bit microcontroller's external memory bus. It holds one 8-bit control register that software writes and reads at special-function address 8Eh. The register sets three things. The first is whether the address-latch strobe runs all the time or only while an external cycle is in progress. The second is the length of the read and write strobes for data moves, either short or long. The third is where each data move goes: to on-chip expansion RAM or to the external bus.

The CPU core raises `mv_start` for one clock when a data move begins, and gives the address and the direction with it. While a code-table read or an external code fetch is in progress, it holds `table_rd` or `ext_fetch` high. If the move goes to internal RAM, the block flags it on `int_sel` in the same clock. If the move goes external, the block drives one active-low read or write strobe.

Top module: `xbs_strobe_ctl`

## Requirements
- R1: The control register is written when `sfr_wr` is high and `sfr_addr` is 8Eh. `sfr_rdata` shows the register while `sfr_addr` is 8Eh and reads 0 at any other address. A write to any other address changes nothing. Bit 6 is reserved and always reads 0.
- R2: After reset the register reads 08h when `secure_ext` is 0 and 0Ah when it is 1. These values mean: bit 7 (pull-up disable) is 0, bit 5 (stretch) is 0, bits 4:2 (size) are 010, bit 1 (external select) copies `secure_ext`, and bit 0 (ALE off) is 0.
- R3: While bit 0 is 0, `ale` is high for exactly one clock in every 6 clocks when `x2_mode` is 0, and one clock in every 3 clocks when `x2_mode` is 1.
- R4: While bit 0 is 1 and no external cycle is present, `ale` is held at a constant 1. An external cycle is present while `table_rd` is high, while `ext_fetch` is high, or while an external strobe is active. During an external cycle, `ale` pulses at the R3 rate.
- R5: When an accepted data move goes external, its strobe starts in the clock after `mv_start`. A read drives `rd_n` low and a write drives `wr_n` low. The strobe lasts 6 clocks when bit 5 is 0 and 30 clocks when bit 5 is 1.
- R6: While bit 1 is 0, a data move goes to internal RAM if its address is below the size limit, and to the external bus otherwise. The size limit is set by bits 4:2: 000 = 256, 001 = 512, 010 = 768, 011 = 1024, and 100 to 111 = 1792.
- R7: While bit 1 is 1, every data move goes to the external bus, whatever its address.
- R8: An internal data move raises `int_sel` in the clock of `mv_start` and drives neither `rd_n` nor `wr_n`.
- R9: The strobe length is taken from bit 5 when the move is accepted. A register write during an active strobe does not change that strobe's length, and a `mv_start` during an active strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x2_mode | input | 1 | Double-speed mode; halves the ALE period |
| secure_ext | input | 1 | Hardware security setting loaded into the external-select bit at reset |
| sfr_wr | input | 1 | Special-function register write strobe |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data |
| mv_start | input | 1 | One-clock pulse that starts a data move |
| mv_write | input | 1 | Direction of the data move: 1 = write |
| mv_addr | input | 16 | Address of the data move |
| table_rd | input | 1 | A code-table read is in progress |
| ext_fetch | input | 1 | An external code fetch is in progress |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | External read strobe, active low |
| wr_n | output | 1 | External write strobe, active low |
| int_sel | output | 1 | The current data move goes to internal RAM |

## Verification
The bench tests the size boundaries one address below and at each limit, including the codes above 100. A design with an off-by-one compare, or one that decodes the upper codes wrongly, sends an edge address the wrong way. It measures the ALE period in both speed modes and checks that ALE stays high while suppressed. A divider bug changes the measured spacing, and a leak in the suppression shows up as low samples. It also writes the register and issues a second move while a long strobe is active. A design that reads the stretch bit live shortens that strobe, and one that does not ignore the second move lengthens it.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned LIM_W  = 12;

  function automatic logic [LIM_W-1:0] xram_limit(input logic [SIZE_W-1:0] code);
    case (code)
      3'd0:    return 12'd256;
      3'd1:    return 12'd512;
      3'd2:    return 12'd768;
      3'd3:    return 12'd1024;
      default: return 12'd1792;
    endcase
  endfunction

  function automatic int unsigned ale_period(input int unsigned div, input logic x2);
    return x2 ? div / 2 : div;
  endfunction
endpackage

// File: rtl/xbs_regs.sv
module xbs_regs #(
  parameter int unsigned        DATA_W    = 8,
  parameter logic [DATA_W-1:0]  CTRL_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_boot,
  input  logic              wr,
  input  logic [DATA_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam logic [DATA_W-1:0] RSVD_MASK = DATA_W'(8'hBF);
  localparam logic [DATA_W-1:0] RST_VAL   = DATA_W'(8'h08);

  logic hit;
  assign hit = (addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= RST_VAL | DATA_W'({ext_boot, 1'b0});
    else if (wr && hit) ctrl_q <= wdata & RSVD_MASK;
  end

  assign rdata = hit ? ctrl_q : '0;
endmodule

// File: rtl/xbs_ale_gen.sv
module xbs_ale_gen #(
  parameter int unsigned ALE_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x2,
  input  logic ale_off,
  input  logic ext_window,
  output logic ale,
  output logic phase_zero
);
  localparam int unsigned PH_W = $clog2(ALE_DIV);
  localparam logic [PH_W-1:0] P_NORM = PH_W'(xbs_pkg::ale_period(ALE_DIV, 1'b0));
  localparam logic [PH_W-1:0] P_FAST = PH_W'(xbs_pkg::ale_period(ALE_DIV, 1'b1));

  logic [PH_W-1:0] phase_q, period;
  logic            wrap;

  assign period = x2 ? P_FAST : P_NORM;
  assign wrap   = (phase_q >= period - PH_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (wrap) phase_q <= '0;
    else           phase_q <= phase_q + PH_W'(1);
  end

  assign phase_zero = (phase_q == '0);
  assign ale        = (ale_off && !ext_window) ? 1'b1 : phase_zero;
endmodule

// File: rtl/xbs_strobe.sv
module xbs_strobe #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 6,
  parameter int unsigned LONG_W  = 30,
  localparam int unsigned CNT_W  = $clog2(LONG_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mv_start,
  input  logic                      mv_write,
  input  logic [ADDR_W-1:0]         mv_addr,
  input  logic                      stretch,
  input  logic                      ext_sel,
  input  logic [xbs_pkg::SIZE_W-1:0] size_code,
  output logic                      rd_n,
  output logic                      wr_n,
  output logic                      int_sel,
  output logic                      busy,
  output logic                      strb_load,
  output logic [CNT_W-1:0]          width_q
);
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic             route_ext;
  logic             accept;

  assign route_ext = ext_sel || (mv_addr >= ADDR_W'(xbs_pkg::xram_limit(size_code)));
  assign busy      = (cnt_q != '0);
  assign accept    = mv_start && !busy;
  assign strb_load = accept && route_ext;
  assign int_sel   = accept && !route_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      width_q <= CNT_W'(SHORT_W);
    end else if (strb_load) begin
      cnt_q   <= stretch ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
      width_q <= stretch ? CNT_W'(LONG_W) : CNT_W'(SHORT_W);
      wr_q    <= mv_write;
    end else if (busy) begin
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign rd_n = !(busy && !wr_q);
  assign wr_n = !(busy && wr_q);
endmodule

// File: rtl/xbs_strobe_ctl.sv
module xbs_strobe_ctl #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  CTRL_ADDR = 8'h8E,
  parameter int unsigned ALE_DIV   = 6,
  parameter int unsigned SHORT_W   = 6,
  parameter int unsigned LONG_W    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x2_mode,
  input  logic              secure_ext,
  input  logic              sfr_wr,
  input  logic [DATA_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              mv_start,
  input  logic              mv_write,
  input  logic [ADDR_W-1:0] mv_addr,
  input  logic              table_rd,
  input  logic              ext_fetch,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              int_sel
);
  localparam int unsigned CNT_W = $clog2(LONG_W + 1);

  logic [DATA_W-1:0] ctrl_q;
  logic              ale_off, ext_sel, stretch;
  logic [2:0]        size_code;
  logic              busy, strb_load, phase_zero, ext_window;
  logic [CNT_W-1:0]  width_q;

  assign ale_off   = ctrl_q[0];
  assign ext_sel   = ctrl_q[1];
  assign size_code = ctrl_q[4:2];
  assign stretch   = ctrl_q[5];
  assign ext_window = table_rd || ext_fetch || busy;

  xbs_regs #(.DATA_W(DATA_W), .CTRL_ADDR(DATA_W'(CTRL_ADDR))) u_regs (
    .clk(clk), .rst_n(rst_n), .ext_boot(secure_ext), .wr(sfr_wr),
    .addr(sfr_addr), .wdata(sfr_wdata), .rdata(sfr_rdata), .ctrl_q(ctrl_q)
  );

  xbs_ale_gen #(.ALE_DIV(ALE_DIV)) u_ale (
    .clk(clk), .rst_n(rst_n), .x2(x2_mode), .ale_off(ale_off),
    .ext_window(ext_window), .ale(ale), .phase_zero(phase_zero)
  );

  xbs_strobe #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_strb (
    .clk(clk), .rst_n(rst_n), .mv_start(mv_start), .mv_write(mv_write),
    .mv_addr(mv_addr), .stretch(stretch), .ext_sel(ext_sel),
    .size_code(size_code), .rd_n(rd_n), .wr_n(wr_n), .int_sel(int_sel),
    .busy(busy), .strb_load(strb_load), .width_q(width_q)
  );
endmodule

// File: rtl/xbs_chk.sv
module xbs_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n,
  input logic             ale_off,
  input logic             table_rd,
  input logic             ext_fetch,
  input logic             int_sel,
  input logic             busy,
  input logic             strb_load,
  input logic             mv_write,
  input logic [CNT_W-1:0] width_q,
  input logic [7:0]       sfr_rdata
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) sfr_rdata[6] == 1'b0); // R1
  AST_ALE_NARROW: assert property (@(posedge clk) disable iff (!rst_n) (!ale_off && ale) |=> (!ale || ale_off)); // R3
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (ale_off && !table_rd && !ext_fetch && rd_n && wr_n) |-> ale); // R4
  AST_STROBE_GO: assert property (@(posedge clk) disable iff (!rst_n) strb_load |=> ($past(mv_write) ? (!wr_n && rd_n) : (!rd_n && wr_n))); // R5
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (int_sel && rd_n && wr_n) |=> (rd_n && wr_n)); // R8
  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(width_q)); // R9
endmodule

bind xbs_strobe_ctl xbs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ale_off(ale_off), .table_rd(table_rd), .ext_fetch(ext_fetch),
  .int_sel(int_sel), .busy(busy), .strb_load(strb_load),
  .mv_write(mv_write), .width_q(width_q), .sfr_rdata(sfr_rdata)
);

// File: tb/tb_xbs_strobe_ctl.sv
module tb_xbs_strobe_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        x2_mode = 1'b0, secure_ext = 1'b0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_addr = 8'h8E, sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        mv_start = 1'b0, mv_write = 1'b0;
  logic [15:0] mv_addr = 16'h0;
  logic        table_rd = 1'b0, ext_fetch = 1'b0;
  logic        ale, rd_n, wr_n, int_sel;

  int nvec = 0, nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xbs_strobe_ctl dut (
    .clk(clk), .rst_n(rst_n), .x2_mode(x2_mode), .secure_ext(secure_ext),
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata), .mv_start(mv_start), .mv_write(mv_write),
    .mv_addr(mv_addr), .table_rd(table_rd), .ext_fetch(ext_fetch),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .int_sel(int_sel)
  );

  function automatic int lim_of(input logic [2:0] code);
    if (code >= 3'd4) return 1792;
    return 256 * (int'(code) + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk); rst_n = 1'b0; secure_ext = boot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_wr = 1'b0; sfr_addr = 8'h8E;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); sfr_addr = a; #1 d = sfr_rdata;
  endtask

  task automatic ale_measure(input int per, input string req);
    int last = -1, nint = 0, bad = 0, wide = 0;
    logic prev = 1'b0;
    repeat (8) @(negedge clk);
    prev = ale;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (ale && !prev) begin
        if (last >= 0) begin nint++; if (i - last != per) bad++; end
        last = i;
      end
      if (ale && prev) wide++;
      prev = ale;
    end
    chk(bad == 0 && nint >= 3, req, bad, 0);
    chk(wide == 0, req, wide, 0);
  endtask

  task automatic do_move(input logic [15:0] a, input logic w, input bit exp_int,
                         input int exp_w, input bit disturb, input string req);
    int cnt = 0;
    logic other_bad = 1'b0;
    @(negedge clk); mv_start = 1'b1; mv_write = w; mv_addr = a;
    #1 chk(int_sel == exp_int, req, int_sel, exp_int);
    @(negedge clk); mv_start = 1'b0;
    while ((w ? wr_n : rd_n) == 1'b0 && cnt < 100) begin
      cnt++;
      if ((w ? rd_n : wr_n) == 1'b0) other_bad = 1'b1;
      if (disturb && cnt == 3) begin
        sfr_wr = 1'b1; sfr_addr = 8'h8E; sfr_wdata = 8'h08; mv_start = 1'b1;
      end else begin
        sfr_wr = 1'b0; mv_start = 1'b0;
      end
      @(negedge clk);
    end
    sfr_wr = 1'b0; mv_start = 1'b0;
    chk(cnt == exp_w && !other_bad, req, cnt, exp_w);
    chk(rd_n && wr_n, req, {rd_n, wr_n}, 3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int lows;
    void'($urandom(32'd2024));

    // R2 reset values
    do_reset(1'b0);
    sfr_read(8'h8E, rv); chk(rv == 8'h08, "R2", rv, 8'h08);
    chk(rd_n && wr_n && !int_sel, "R2", {rd_n, wr_n, int_sel}, 6);
    do_reset(1'b1);
    sfr_read(8'h8E, rv); chk(rv == 8'h0A, "R2", rv, 8'h0A);
    do_reset(1'b0);

    // R1 register access
    sfr_write(8'h8E, 8'hFF);
    sfr_read(8'h8E, rv); chk(rv == 8'hBF, "R1", rv, 8'hBF);
    sfr_write(8'h8F, 8'h00);
    sfr_read(8'h8E, rv); chk(rv == 8'hBF, "R1", rv, 8'hBF);
    sfr_read(8'h8F, rv); chk(rv == 8'h00, "R1", rv, 0);
    sfr_write(8'h8E, 8'h08);

    // R3 ALE rate
    x2_mode = 1'b0; ale_measure(6, "R3");
    x2_mode = 1'b1; ale_measure(3, "R3");
    x2_mode = 1'b0;

    // R4 ALE suppression
    sfr_write(8'h8E, 8'h09);
    lows = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (!ale) lows++; end
    chk(lows == 0, "R4", lows, 0);
    do_move(16'h0010, 1'b0, 1'b1, 0, 1'b0, "R4");
    chk(ale == 1'b1, "R4", ale, 1);
    @(negedge clk); table_rd = 1'b1; lows = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (!ale) lows++; end
    chk(lows == 10, "R4", lows, 10);
    table_rd = 1'b0; ext_fetch = 1'b1; lows = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (!ale) lows++; end
    chk(lows == 10, "R4", lows, 10);
    ext_fetch = 1'b0;
    sfr_write(8'h8E, 8'h08);

    // R5 strobe widths
    do_move(16'hF000, 1'b0, 1'b0, 6, 1'b0, "R5");
    do_move(16'hF000, 1'b1, 1'b0, 6, 1'b0, "R5");
    sfr_write(8'h8E, 8'h28);
    do_move(16'h0300, 1'b1, 1'b0, 30, 1'b0, "R5");

    // R9 stretch latched, start ignored while busy
    do_move(16'h8000, 1'b0, 1'b0, 30, 1'b1, "R9");
    sfr_read(8'h8E, rv); chk(rv == 8'h08, "R9", rv, 8'h08);

    // R6 boundaries
    sfr_write(8'h8E, 8'h08);
    do_move(16'd767, 1'b0, 1'b1, 0, 1'b0, "R6");
    do_move(16'd768, 1'b0, 1'b0, 6, 1'b0, "R6");
    sfr_write(8'h8E, 8'h00);
    do_move(16'd255, 1'b1, 1'b1, 0, 1'b0, "R6");
    do_move(16'd256, 1'b1, 1'b0, 6, 1'b0, "R6");
    sfr_write(8'h8E, 8'h10);
    do_move(16'd1791, 1'b0, 1'b1, 0, 1'b0, "R6");
    do_move(16'd1792, 1'b0, 1'b0, 6, 1'b0, "R6");
    sfr_write(8'h8E, 8'h1C);
    do_move(16'd1791, 1'b0, 1'b1, 0, 1'b0, "R6");
    do_move(16'd1792, 1'b0, 1'b0, 6, 1'b0, "R6");

    // R7 external select
    sfr_write(8'h8E, 8'h0A);
    do_move(16'h0000, 1'b0, 1'b0, 6, 1'b0, "R7");
    do_move(16'h0001, 1'b1, 1'b0, 6, 1'b0, "R7");

    // R8 random routing
    for (int k = 0; k < 40; k++) begin
      logic [2:0]  code;
      logic        ex, st, w;
      logic [15:0] a;
      bit          ei;
      code = 3'($urandom);
      ex   = ($urandom % 4) == 0;
      st   = 1'($urandom);
      w    = 1'($urandom);
      a    = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 2048);
      ei   = !ex && (int'(a) < lim_of(code));
      sfr_write(8'h8E, {2'b00, st, code, ex, 1'b0});
      do_move(a, w, ei, ei ? 0 : (st ? 30 : 6), 1'b0, "R8");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule